// File: doc/BRIEF.md
# Pin Edge-Detect Interrupt Unit

This unit watches the input levels of a 32-pin port and turns level changes into interrupt flags, a port interrupt request and single-cycle event pulses. Each pin is first brought into the clock domain by a two-stage synchronizer. It may then pass through an optional glitch filter, and finally reaches an edge detector. The edge detector can be programmed to fire on any change, on rising edges only or on falling edges only.

A detected edge does two things. It sets a sticky per-pin flag, and it produces a one-cycle pulse on a per-pin event output, which goes to an event-routing fabric. The flags are masked by per-pin enables and combined into one registered interrupt request. Software sees a small word-addressed register file. The edge mode, filter enable and interrupt enable each have separate set and clear addresses, and the flags have a write-one-to-clear address. The event path works whether or not interrupts are enabled.

Top module: `pin_irq_unit`

## Requirements
- R1: The edge mode of pin n is given by bit n of register EDGE_A (read at address 0) and bit n of register EDGE_B (read at address 3). {EDGE_B,EDGE_A}=00 detects both edges, 01 detects rising edges only and 10 detects falling edges only.
- R2: A mode write that would leave any pin with both EDGE_A and EDGE_B set is not applied for that pin, and its two bits keep their old values. Other pins in the same write are updated normally.
- R3: Each configuration register has a set address and a clear address. A write sets or clears the register bits where the write data is 1 and leaves the bits where it is 0 unchanged. The addresses are: EDGE_A set 1 and clear 2; EDGE_B set 4 and clear 5; filter enable read 6, set 7, clear 8; interrupt enable read 9, set 10, clear 11.
- R4: irq_o is a register holding the OR over all pins of (flag AND interrupt enable). It follows a change of a flag or of an enable one clock later, and it stays 0 while no pin with a set flag is enabled.
- R5: The flag of a pin is set by a detected edge and holds until software writes 1 to its bit at address 13. The flags are read at address 12. If an edge and a clear of the same pin fall in the same cycle, the flag stays set.
- R6: When a pin's filter is enabled, a new level is accepted only after the synchronized level has been equal on two consecutive clock samples. A one-cycle pulse on the pin is ignored, and the filter adds two cycles of latency.
- R7: Each detected edge gives a one-cycle pulse on evt_o for its pin, whatever the state of the flag and the enable. Without the filter, the pulse and the flag appear after the third rising clock edge following the pin change. With the filter, they appear after the fifth.
- R8: After reset, every configuration register and every flag is 0, and evt_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Asynchronous pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address (read and write) |
| reg_wdata_i | input | 32 | Write data, one bit per pin |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, 0 for write-only addresses |
| evt_o | output | 32 | Per-pin single-cycle edge event |
| irq_o | output | 1 | Registered port interrupt request |

## Verification
The interesting collision is a flag clear written in the same cycle that a new edge on the same pin registers its flag. The bench drives a pin change, counts two clock cycles, and then issues the clear so that it lands on the edge that captures the detection. In that same write it also clears a second pin whose flag was already set. The flag register is then read back. The pin with the fresh edge must still show 1, and the other pin must show 0.

// File: rtl/piu_pkg.sv
package piu_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    REG_EDGE_A     = 4'd0,
    REG_EDGE_A_SET = 4'd1,
    REG_EDGE_A_CLR = 4'd2,
    REG_EDGE_B     = 4'd3,
    REG_EDGE_B_SET = 4'd4,
    REG_EDGE_B_CLR = 4'd5,
    REG_FILT       = 4'd6,
    REG_FILT_SET   = 4'd7,
    REG_FILT_CLR   = 4'd8,
    REG_IEN        = 4'd9,
    REG_IEN_SET    = 4'd10,
    REG_IEN_CLR    = 4'd11,
    REG_FLAG       = 4'd12,
    REG_FLAG_CLR   = 4'd13
  } piu_reg_e;
endpackage

// File: rtl/piu_regs.sv
module piu_regs
  import piu_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] flag_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic [NUM_PINS-1:0] edge_a_o,
  output logic [NUM_PINS-1:0] edge_b_o,
  output logic [NUM_PINS-1:0] filt_o,
  output logic [NUM_PINS-1:0] ien_o,
  output logic [NUM_PINS-1:0] flag_clr_o
);
  logic [NUM_PINS-1:0] edge_a_q, edge_b_q, filt_q, ien_q;
  logic [NUM_PINS-1:0] a_nxt, b_nxt, bad;

  function automatic logic [NUM_PINS-1:0] strobe(input logic [REG_AW-1:0] a);
    return (we_i && addr_i == a) ? wdata_i : '0;
  endfunction

  always_comb begin
    a_nxt = (edge_a_q | strobe(REG_EDGE_A_SET)) & ~strobe(REG_EDGE_A_CLR);
    b_nxt = (edge_b_q | strobe(REG_EDGE_B_SET)) & ~strobe(REG_EDGE_B_CLR);
    bad   = a_nxt & b_nxt;  // code 11 is rejected per pin
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_a_q <= '0;
      edge_b_q <= '0;
      filt_q   <= '0;
      ien_q    <= '0;
    end else begin
      edge_a_q <= (a_nxt & ~bad) | (edge_a_q & bad);
      edge_b_q <= (b_nxt & ~bad) | (edge_b_q & bad);
      filt_q   <= (filt_q | strobe(REG_FILT_SET)) & ~strobe(REG_FILT_CLR);
      ien_q    <= (ien_q | strobe(REG_IEN_SET)) & ~strobe(REG_IEN_CLR);
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_EDGE_A: rdata_o = edge_a_q;
      REG_EDGE_B: rdata_o = edge_b_q;
      REG_FILT:   rdata_o = filt_q;
      REG_IEN:    rdata_o = ien_q;
      REG_FLAG:   rdata_o = flag_i;
      default:    rdata_o = '0;
    endcase
  end

  assign edge_a_o   = edge_a_q;
  assign edge_b_o   = edge_b_q;
  assign filt_o     = filt_q;
  assign ien_o      = ien_q;
  assign flag_clr_o = strobe(REG_FLAG_CLR);

  AST_MODE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_a_q & edge_b_q) == '0); // R2
endmodule

// File: rtl/piu_pin_path.sv
module piu_pin_path #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic filt_en_i,
  input  logic edge_a_i,
  input  logic edge_b_i,
  output logic det_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic s_lvl, prev_q, flt_q, lvl, lvl_q, rise, fall;

  assign s_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      flt_q  <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= s_lvl;
      if (s_lvl == prev_q) flt_q <= s_lvl;  // two equal samples
      lvl_q  <= lvl;
    end
  end

  assign lvl  = filt_en_i ? flt_q : s_lvl;
  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

  always_comb begin
    if (edge_a_i)      det_o = rise;
    else if (edge_b_i) det_o = fall;
    else               det_o = rise | fall;
  end

  AST_FILT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_q != $past(flt_q)) |-> ($past(s_lvl, 1) == $past(s_lvl, 2))); // R6
endmodule

// File: rtl/piu_flags.sv
module piu_flags #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] det_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic [NUM_PINS-1:0] ien_i,
  output logic [NUM_PINS-1:0] flag_o,
  output logic [NUM_PINS-1:0] evt_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] flag_q, evt_q;
  logic                irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      evt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_i) | det_i;  // set wins over clear
      evt_q  <= det_i;
      irq_q  <= |(flag_q & ien_i);
    end
  end

  assign flag_o = flag_q;
  assign evt_o  = evt_q;
  assign irq_o  = irq_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flag_q) & ~$past(clr_i)) & ~flag_q) == '0); // R5
  AST_EVT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q & ~flag_q) == '0); // R7
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(|ien_i)); // R4
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import piu_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [NUM_PINS-1:0] reg_wdata_i,
  output logic [NUM_PINS-1:0] reg_rdata_o,
  output logic [NUM_PINS-1:0] evt_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] edge_a, edge_b, filt, ien, flag_clr, flag, det;

  piu_regs #(.NUM_PINS(NUM_PINS)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flag_i(flag), .rdata_o(reg_rdata_o),
    .edge_a_o(edge_a), .edge_b_o(edge_b), .filt_o(filt), .ien_o(ien),
    .flag_clr_o(flag_clr)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    piu_pin_path i_path (
      .clk_i, .rst_ni,
      .pin_i(pins_i[p]), .filt_en_i(filt[p]),
      .edge_a_i(edge_a[p]), .edge_b_i(edge_b[p]),
      .det_o(det[p])
    );
  end

  piu_flags #(.NUM_PINS(NUM_PINS)) i_flags (
    .clk_i, .rst_ni,
    .det_i(det), .clr_i(flag_clr), .ien_i(ien),
    .flag_o(flag), .evt_o(evt_o), .irq_o(irq_o)
  );
endmodule

// File: tb/test_pin_irq_unit.sv
module test_pin_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, evt;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_unit i_pin_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .evt_o(evt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cleanup();
    pins = '0;
    step(8);
    wr(4'd13, '1);
    step(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    foreach (d[i]) ;
    rd(4'd0, d); chk("R8 edge_a", d, 0);
    rd(4'd3, d); chk("R8 edge_b", d, 0);
    rd(4'd6, d); chk("R8 filt", d, 0);
    rd(4'd9, d); chk("R8 ien", d, 0);
    rd(4'd12, d); chk("R8 flag", d, 0);
    chk("R8 evt", evt, 0);
    chk("R8 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_any_change();
    logic [31:0] d;
    pins[0] = 1'b1;
    step(2); chk("R7 evt early", evt, 0);
    step(1); chk("R7 evt rise any", evt, 32'h1);
    rd(4'd12, d); chk("R1 R5 flag any", d, 32'h1);
    step(1); chk("R7 evt one cycle", evt, 0);
    pins[0] = 1'b0;  // flag still set: event must fire anyway
    step(3); chk("R7 evt fall any", evt, 32'h1);
    step(1); chk("R7 evt single", evt, 0);
    rd(4'd12, d); chk("R5 sticky", d, 32'h1);
    wr(4'd13, 32'h1);
    rd(4'd12, d); chk("R5 w1c", d, 0);
    cleanup();
  endtask

  task automatic t_rising();
    logic [31:0] d;
    logic [31:0] seen = '0;
    wr(4'd1, 32'h2);
    pins[1] = 1'b1;
    step(3); chk("R1 rising evt", evt, 32'h2);
    wr(4'd13, 32'h2);
    pins[1] = 1'b0;
    for (int i = 0; i < 6; i++) begin step(1); seen |= evt; end
    chk("R1 rising ignores fall", seen, 0);
    rd(4'd12, d); chk("R1 rising no flag", d, 0);
    cleanup();
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    logic [31:0] seen = '0;
    wr(4'd4, 32'h0000_000A);  // pin1 has EDGE_A set: rejected
    rd(4'd3, d); chk("R2 edge_b", d, 32'h8);
    rd(4'd0, d); chk("R2 edge_a kept", d, 32'h2);
    pins[3] = 1'b1;
    for (int i = 0; i < 6; i++) begin step(1); seen |= evt; end
    chk("R1 falling ignores rise", seen, 0);
    pins[3] = 1'b0;
    step(3); chk("R1 falling evt", evt, 32'h8);
    wr(4'd2, 32'h2);
    wr(4'd5, 32'h8);
    rd(4'd0, d); chk("R3 edge_a clr", d, 0);
    cleanup();
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(4'd7, 32'hF0);
    wr(4'd8, 32'h30);
    rd(4'd6, d); chk("R3 filt set/clr", d, 32'hC0);
    wr(4'd10, 32'h0F00);
    wr(4'd10, 32'h1000);
    wr(4'd11, 32'h0100);
    rd(4'd9, d); chk("R3 ien set/clr", d, 32'h1E00);
    wr(4'd8, '1);
    wr(4'd11, '1);
    rd(4'd6, d); chk("R3 filt cleared", d, 0);
  endtask

  task automatic t_irq();
    pins[4] = 1'b1;
    step(3); chk("R7 evt without ien", evt, 32'h10);
    step(2); chk("R4 irq masked", {31'd0, irq}, 0);
    wr(4'd10, 32'h10);
    chk("R4 irq lag", {31'd0, irq}, 0);
    step(1); chk("R4 irq on", {31'd0, irq}, 1);
    wr(4'd13, 32'h10);
    chk("R4 irq holds one cycle", {31'd0, irq}, 1);
    step(1); chk("R4 irq off", {31'd0, irq}, 0);
    wr(4'd11, 32'h10);
    cleanup();
  endtask

  task automatic t_filter();
    logic [31:0] d;
    logic [31:0] seen = '0;
    wr(4'd7, 32'h20);
    step(2);
    pins[5] = 1'b1;
    step(1);
    pins[5] = 1'b0;
    for (int i = 0; i < 8; i++) begin step(1); seen |= evt; end
    chk("R6 glitch rejected", seen, 0);
    rd(4'd12, d); chk("R6 glitch no flag", d, 0);
    pins[5] = 1'b1;
    step(4); chk("R6 filtered early", evt, 0);
    step(1); chk("R6 filtered evt", evt, 32'h20);
    pins[5] = 1'b0;
    step(5); chk("R6 filtered fall", evt, 32'h20);
    wr(4'd8, 32'h20);
    cleanup();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pins[6] = 1'b1;
    step(4);
    pins[7] = 1'b1;
    step(2);
    wr(4'd13, 32'hC0);  // lands on the edge that captures pin 7
    rd(4'd12, d); chk("R5 set beats clear", d, 32'h80);
    chk("R7 evt at collision", evt, 32'h80);
    cleanup();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_any_change();
    t_rising();
    t_invalid();
    t_setclr();
    t_irq();
    t_filter();
    t_collide();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule